// File: doc/BRIEF.md
# Dual-Channel Event Timer with 64-bit Snapshot Counter

This peripheral gives software two independent 32-bit event channels and one 64-bit free-running time base, all reached through a simple single-cycle register bus. Each event channel owns an up-counter, a compare value and a control word. The control word holds a three-bit run field and a prescaler. Software arms a channel in three steps: it zeroes the counter, writes the wanted distance into the compare register, and then sets the run field. The channel raises a sticky status bit when its count steps onto the compare value. That status bit, gated by the run field, drives the channel's interrupt line.

The 64-bit time base always counts, at a rate set by its own prescaler. Software controls it through command bits in a shared control word. One command loads the counter from a pair of staging registers. The other freezes the whole 64-bit value into a pair of snapshot registers in a single clock, so the two halves can be read one after the other and still agree.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and `irq_o` is low.
- R2: A channel counts only while its control bits [2:0] are all ones (3'b111). Any other value of those bits holds the counter and masks the interrupt.
- R3: With prescaler value N in control bits [31:16], a running channel counter advances once every N+1 clocks. The first step lands N+1 clocks after the write that starts the channel, because the prescaler restarts on every transition from stopped to running.
- R4: Status bit i (bit 0 for channel 0, bit 1 for channel 1) sets in the same clock as the step that brings channel i's count equal to its compare value. The channel then keeps counting and wraps at 2^32.
- R5: A write to the status register clears each bit where the write data holds a one. A status set that lands in the same clock as a clear of that bit wins, and the bit stays set.
- R6: `irq_o[i]` is high exactly while status bit i is set and channel i is running. Stopping a channel lowers its interrupt and leaves its status bit set.
- R7: A bus write to a channel counter takes effect on the next clock edge, and it overrides a prescaled step that falls on that same edge.
- R8: The 64-bit counter runs at all times and advances once every N+1 clocks, with N in bits [31:16] of the wide control word. Its live halves can be read at any time.
- R9: Writing the wide control word with bit 0 = 1 and bit 1 = 0 copies the counter value held just before that edge into the snapshot low and high registers.
- R10: Writing the wide control word with bits [1:0] = 2'b11 loads the counter from the staging registers and restarts its prescaler. The value 2'b10 does nothing. Command bits read back as zero.
- R11: Register map, as byte addresses. Channel i control is at 0x10*i, its compare value at 0x10*i+4 and its counter at 0x10*i+8. The status register is at 0x40 and the wide control word at 0x44. The live counter is at 0x48 (low) and 0x4C (high), the staging registers at 0x50 and 0x54, and the snapshot registers at 0x58 and 0x5C. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one clock per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the clock the read is presented |
| irq_o | output | 2 | Per-channel interrupt |

## Verification
A channel's compare hit can fall in the same clock as a software write-one-to-clear of its status bit. Likewise, a prescaled step can fall in the same clock as a software write to that channel's counter. The bench computes the exact edge of each hit and each step from the prescaler and the distance it programmed. It then places the clear write, or the counter write, on that edge. The result is judged by reading the status bit, or the counter, right after that edge and again after the following write or step.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 8;
  localparam int EN_W = 3;
  localparam logic [ADDR_W-1:0] GLB_BASE = 8'h40;

  typedef enum logic [1:0] {C_CTRL = 2'd0, C_MATCH = 2'd1, C_CNT = 2'd2, C_RSVD = 2'd3} ch_reg_e;
  typedef enum logic [2:0] {
    G_STAT = 3'd0, G_WCTRL = 3'd1, G_LIVE_LO = 3'd2, G_LIVE_HI = 3'd3,
    G_LOAD_LO = 3'd4, G_LOAD_HI = 3'd5, G_SNAP_LO = 3'd6, G_SNAP_HI = 3'd7
  } glb_reg_e;

  function automatic logic [ADDR_W-1:0] ch_addr(int ch, ch_reg_e r);
    return ADDR_W'(ch * 16 + int'(r) * 4);
  endfunction

  function automatic logic [ADDR_W-1:0] glb_addr(glb_reg_e r);
    return GLB_BASE + ADDR_W'(int'(r) * 4);
  endfunction
endpackage

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] pc_q;

  // >= keeps the divider safe when div shrinks below the running count
  assign tick_o = run_i && !restart_i && (pc_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (!run_i || restart_i || tick_o) pc_q <= '0;
    else pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/evt_chan.sv
module evt_chan import evt_timer_pkg::*; #(
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          match_we_i,
  input  logic          cnt_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] cnt_o,
  output logic          run_o,
  output logic          hit_o
);
  localparam int PS_LSB = DW - PW;

  logic [EN_W-1:0] en_q;
  logic [PW-1:0]   div_q;
  logic [DW-1:0]   match_q, cnt_q, cnt_nxt;
  logic            tick;

  assign run_o   = &en_q;
  assign cnt_nxt = cnt_q + 1'b1;

  evt_prescale #(.PW(PW)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_o),
    .restart_i(1'b0),
    .div_i    (div_q),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      div_q   <= '0;
      match_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= wdata_i[EN_W-1:0];
        div_q <= wdata_i[DW-1:PS_LSB];
      end
      if (match_we_i) match_q <= wdata_i;
      if (cnt_we_i) cnt_q <= wdata_i;
      else if (tick) cnt_q <= cnt_nxt;
    end
  end

  // hit on the step that lands on the compare value
  assign hit_o = tick && !cnt_we_i && (cnt_nxt == match_q);

  always_comb begin
    ctrl_o = '0;
    ctrl_o[EN_W-1:0]    = en_q;
    ctrl_o[DW-1:PS_LSB] = div_q;
  end
  assign match_o = match_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/evt_wide.sv
module evt_wide #(
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   ctrl_o,
  output logic [2*DW-1:0] cnt_o,
  output logic [2*DW-1:0] snap_o,
  output logic [2*DW-1:0] load_o
);
  localparam int PS_LSB = DW - PW;

  logic [PW-1:0]   div_q;
  logic [2*DW-1:0] cnt_q, snap_q;
  logic [DW-1:0]   load_lo_q, load_hi_q;
  logic            snap_cmd, load_cmd, tick;

  assign snap_cmd = ctrl_we_i && wdata_i[0] && !wdata_i[1];
  assign load_cmd = ctrl_we_i && wdata_i[0] && wdata_i[1];

  evt_prescale #(.PW(PW)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (1'b1),
    .restart_i(load_cmd),
    .div_i    (div_q),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      cnt_q     <= '0;
      snap_q    <= '0;
      load_lo_q <= '0;
      load_hi_q <= '0;
    end else begin
      if (ctrl_we_i) div_q <= wdata_i[DW-1:PS_LSB];
      if (lo_we_i) load_lo_q <= wdata_i;
      if (hi_we_i) load_hi_q <= wdata_i;
      if (load_cmd) cnt_q <= {load_hi_q, load_lo_q};
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (snap_cmd) snap_q <= cnt_q;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[DW-1:PS_LSB] = div_q;
  end
  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign load_o = {load_hi_q, load_lo_q};
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_timer_pkg::*; #(
  parameter int NUM_CH = 2,   // at most 4 with this map
  parameter int DW     = 32,
  parameter int PW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic wr_en, rd_en;
  logic [NUM_CH-1:0] ch_run, ch_hit, status_q, clr_mask;
  logic [NUM_CH-1:0][DW-1:0] ch_ctrl, ch_match, ch_cnt;
  logic [DW-1:0]   wide_ctrl;
  logic [2*DW-1:0] wide_cnt, wide_snap, wide_load;

  assign wr_en = req_i && we_i;
  assign rd_en = req_i && !we_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evt_chan #(.DW(DW), .PW(PW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (wr_en && addr_i == ch_addr(g, C_CTRL)),
      .match_we_i(wr_en && addr_i == ch_addr(g, C_MATCH)),
      .cnt_we_i  (wr_en && addr_i == ch_addr(g, C_CNT)),
      .wdata_i   (wdata_i),
      .ctrl_o    (ch_ctrl[g]),
      .match_o   (ch_match[g]),
      .cnt_o     (ch_cnt[g]),
      .run_o     (ch_run[g]),
      .hit_o     (ch_hit[g])
    );
  end

  evt_wide #(.DW(DW), .PW(PW)) u_wide (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(wr_en && addr_i == glb_addr(G_WCTRL)),
    .lo_we_i  (wr_en && addr_i == glb_addr(G_LOAD_LO)),
    .hi_we_i  (wr_en && addr_i == glb_addr(G_LOAD_HI)),
    .wdata_i  (wdata_i),
    .ctrl_o   (wide_ctrl),
    .cnt_o    (wide_cnt),
    .snap_o   (wide_snap),
    .load_o   (wide_load)
  );

  assign clr_mask = (wr_en && addr_i == glb_addr(G_STAT)) ? wdata_i[NUM_CH-1:0] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else status_q <= (status_q & ~clr_mask) | ch_hit;
  end

  assign irq_o = status_q & ch_run;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == ch_addr(i, C_CTRL))  rdata_o = ch_ctrl[i];
        if (addr_i == ch_addr(i, C_MATCH)) rdata_o = ch_match[i];
        if (addr_i == ch_addr(i, C_CNT))   rdata_o = ch_cnt[i];
      end
      if (addr_i == glb_addr(G_STAT))    rdata_o = DW'(status_q);
      if (addr_i == glb_addr(G_WCTRL))   rdata_o = wide_ctrl;
      if (addr_i == glb_addr(G_LIVE_LO)) rdata_o = wide_cnt[DW-1:0];
      if (addr_i == glb_addr(G_LIVE_HI)) rdata_o = wide_cnt[2*DW-1:DW];
      if (addr_i == glb_addr(G_LOAD_LO)) rdata_o = wide_load[DW-1:0];
      if (addr_i == glb_addr(G_LOAD_HI)) rdata_o = wide_load[2*DW-1:DW];
      if (addr_i == glb_addr(G_SNAP_LO)) rdata_o = wide_snap[DW-1:0];
      if (addr_i == glb_addr(G_SNAP_HI)) rdata_o = wide_snap[2*DW-1:DW];
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk import evt_timer_pkg::*; #(
  parameter int NUM_CH = 2,
  parameter int DW     = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic [NUM_CH-1:0]         irq_o,
  input logic [NUM_CH-1:0]         status_q,
  input logic [NUM_CH-1:0]         ch_run,
  input logic [NUM_CH-1:0]         ch_hit,
  input logic [NUM_CH-1:0][DW-1:0] ch_cnt,
  input logic [2*DW-1:0]           wide_cnt,
  input logic [2*DW-1:0]           wide_snap,
  input logic [2*DW-1:0]           wide_load
);
  localparam logic [2*DW-1:0] ONE = 1;

  logic wr, wide_cmd, stat_wr, load_go, snap_go;
  assign wr       = req_i && we_i;
  assign wide_cmd = wr && addr_i == glb_addr(G_WCTRL);
  assign stat_wr  = wr && addr_i == glb_addr(G_STAT);
  assign load_go  = wide_cmd && wdata_i[1:0] == 2'b11;
  assign snap_go  = wide_cmd && wdata_i[1:0] == 2'b01;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    a_r5_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_hit[g] |=> status_q[g]);
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_q[g] && !(stat_wr && wdata_i[g]) |=> status_q[g]);
    a_r6_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run[g] |-> !irq_o[g]);
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run[g] && !(wr && addr_i == ch_addr(g, C_CNT)) |=> $stable(ch_cnt[g]));
  end

  a_r9_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_go |=> wide_snap == $past(wide_cnt));
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_go |=> wide_cnt == $past(wide_load));
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_go |=> (wide_cnt == $past(wide_cnt) || wide_cnt == $past(wide_cnt) + ONE));
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .ch_run   (ch_run),
  .ch_hit   (ch_hit),
  .ch_cnt   (ch_cnt),
  .wide_cnt (wide_cnt),
  .wide_snap(wide_snap),
  .wide_load(wide_load)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  import evt_timer_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0] irq_o;

  int unsigned edges = 0;
  int unsigned last_wr = 0;
  int n_tests = 0, n_fail = 0;

  evt_timer u_dut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) edges <= edges + 1;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    last_wr = edges + 1;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic wait_until(int unsigned t);
    while (edges < t) @(negedge clk_i);
  endtask

  function automatic logic [63:0] wide_at(logic [63:0] v, int unsigned steps_from, int unsigned e, int n);
    return v + 64'((e - steps_from) / (n + 1));
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int unsigned e, f;
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state, R11 unmapped reads
    peek(ch_addr(0, C_CTRL), d);  check("R1 ctrl0", d, 0);
    peek(ch_addr(1, C_CNT), d);   check("R1 cnt1", d, 0);
    peek(glb_addr(G_STAT), d);    check("R1 status", d, 0);
    peek(glb_addr(G_SNAP_HI), d); check("R1 snap_hi", d, 0);
    check("R1 irq", irq_o, 0);
    peek(8'h3C, d);               check("R11 unmapped", d, 0);
    peek(8'h0C, d);               check("R11 reserved", d, 0);

    // R4 R6 directed: N=0, compare 5
    wr(ch_addr(0, C_CNT), 0);
    wr(ch_addr(0, C_MATCH), 5);
    wr(ch_addr(0, C_CTRL), 32'h7); e = last_wr;
    wait_until(e + 4);
    check("R4 no early hit", irq_o[0], 0);
    wait_until(e + 5);
    peek(glb_addr(G_STAT), d);    check("R4 status on hit", d, 1);
    check("R6 irq on hit", irq_o[0], 1);
    wait_until(e + 7);
    peek(ch_addr(0, C_CNT), d);   check("R4 counts past match", d, 7);

    // R6 stop masks, R2 hold and partial enable
    wr(ch_addr(0, C_CTRL), 0);
    check("R6 irq masked", irq_o[0], 0);
    peek(glb_addr(G_STAT), d);    check("R6 status kept", d, 1);
    peek(ch_addr(0, C_CNT), d);
    repeat (3) @(negedge clk_i);
    peek(ch_addr(0, C_CNT), d2);  check("R2 stopped hold", d2, d);
    wr(ch_addr(0, C_CTRL), 32'h3);
    repeat (3) @(negedge clk_i);
    peek(ch_addr(0, C_CNT), d2);  check("R2 partial enable hold", d2, d);
    check("R6 partial enable irq", irq_o[0], 0);
    wr(glb_addr(G_STAT), 32'hFFFF_FFFF);
    peek(glb_addr(G_STAT), d);    check("R5 clear all", d, 0);

    // R3 prescale, R5 set-vs-clear collision, R7 write-vs-step on ch1
    wr(ch_addr(1, C_CNT), 0);
    wr(ch_addr(1, C_MATCH), 4);
    wr(ch_addr(1, C_CTRL), (32'd3 << 16) | 32'h7); e = last_wr;
    f = e + 16;
    wait_until(e + 7);
    peek(ch_addr(1, C_CNT), d);   check("R3 N=3 count at +7", d, 1);
    wait_until(e + 8);
    peek(ch_addr(1, C_CNT), d);   check("R3 N=3 count at +8", d, 2);
    wait_until(f - 1);
    peek(glb_addr(G_STAT), d);    check("R5 before hit", d[1], 0);
    wr(glb_addr(G_STAT), 2);      // lands on hit edge f
    peek(glb_addr(G_STAT), d);    check("R5 set wins", d[1], 1);
    wr(glb_addr(G_STAT), 2);
    peek(glb_addr(G_STAT), d);    check("R5 w1c", d[1], 0);
    wait_until(e + 19);
    wr(ch_addr(1, C_CNT), 100);   // lands on step edge e+20
    peek(ch_addr(1, C_CNT), d);   check("R7 write beats step", d, 100);
    wait_until(e + 24);
    peek(ch_addr(1, C_CNT), d);   check("R7 resumes", d, 101);
    wr(ch_addr(1, C_CTRL), 0);
    wr(glb_addr(G_STAT), 3);

    // R3 R4 random arming on both channels
    for (int it = 0; it < 8; it++) begin
      int ch = it % 2;
      int n = $urandom_range(0, 3);
      int dl = $urandom_range(1, 12);
      wr(ch_addr(ch, C_CTRL), 0);
      wr(glb_addr(G_STAT), 3);
      wr(ch_addr(ch, C_CNT), 0);
      wr(ch_addr(ch, C_MATCH), dl);
      wr(ch_addr(ch, C_CTRL), (32'(n) << 16) | 32'h7); e = last_wr;
      f = e + dl * (n + 1);
      wait_until(f - 1);
      check("R3 random no early irq", irq_o[ch], 0);
      wait_until(f);
      check("R4 random irq at hit", irq_o[ch], 1);
    end
    wr(ch_addr(0, C_CTRL), 0);
    wr(ch_addr(1, C_CTRL), 0);

    // R8 R9 R10 wide counter
    for (int it = 0; it < 5; it++) begin
      logic [63:0] v, exp;
      int n = $urandom_range(0, 3);
      int unsigned l, s;
      v = (it == 0) ? 64'h0000_0001_FFFF_FFFE :
          (it == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom(), $urandom()};
      wr(glb_addr(G_LOAD_LO), v[31:0]);
      wr(glb_addr(G_LOAD_HI), v[63:32]);
      wr(glb_addr(G_WCTRL), (32'(n) << 16) | 32'h3); l = last_wr;
      peek(glb_addr(G_WCTRL), d);  check("R10 cmd bits read zero", d, 32'(n) << 16);
      wait_until(l + $urandom_range(1, 20));
      peek(glb_addr(G_LIVE_LO), d);
      exp = wide_at(v, l, edges, n);
      check("R8 live low", d, exp[31:0]);
      wr(glb_addr(G_WCTRL), (32'(n) << 16) | 32'h1); s = last_wr;
      exp = wide_at(v, l, s - 1, n);
      peek(glb_addr(G_SNAP_LO), d); check("R9 snap low", d, exp[31:0]);
      peek(glb_addr(G_SNAP_HI), d); check("R9 snap high", d, exp[63:32]);
      wr(glb_addr(G_WCTRL), (32'(n) << 16) | 32'h2);
      repeat (2) @(negedge clk_i);
      wr(glb_addr(G_WCTRL), (32'(n) << 16) | 32'h1); s = last_wr;
      exp = wide_at(v, l, s - 1, n);
      peek(glb_addr(G_SNAP_LO), d); check("R10 2'b10 no load", d, exp[31:0]);
      peek(glb_addr(G_SNAP_HI), d); check("R10 2'b10 no load hi", d, exp[63:32]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule